// File: doc/BRIEF.md
# Gate Pulse Output Sequencer

This controller picks which of four sources drives a gate-voltage output node: ground, the high rail, the low reference (the falling ramp), or nothing at all. Its inputs are comparator flags that have already been brought into the clock domain. These flags report the enable pin, the enable-delay threshold, input supply above undervoltage lockout, the high rail above 3 V, the supply-monitor reset, the control input from the timing controller, and the delay pin held high. The outputs are a 2-bit drive select and two commands for the delay capacitor: charge and clear.

In normal operation the output follows the control input. While the control input is high, the high rail is selected. After a falling edge of the control input, a programmable cycle count stands in for the capacitor-set delay, and the output moves to the low reference only when that count runs out. Tying the delay pin high, or programming a count of zero, removes the delay. Supply loss and monitor reset override the normal sequence. The output is held at the high rail while that rail is still above 3 V, and is released once it collapses.

Top module: `gate_pulse_seq`

## Requirements
- R1: Drive select encoding is 00 ground, 01 high rail, 10 low reference, 11 undriven. With the supply above lockout and either the enable pin or the enable-delay flag low, the select is 00 whatever the other inputs are.
- R2: When enabled with supply good, monitor reset high and control input high, the select is 01. The clear command is high exactly while the control input is high and the delay pin is not held high.
- R3: With the delay pin low and a count N of 1 or more, a falling control input raises the charge command at once. The select stays 01 until the N-th rising clock edge that samples the control input low, and reads 10 after that edge.
- R4: With the delay pin held high, the select reads 10 in the same cycle the control input is low, and the charge command stays low.
- R5: A programmed count of zero behaves like R4: the select is 10 at once, and no charge is commanded.
- R6: A rising control input during a pending delay returns the select to 01 in the same cycle. The following falling edge waits the full count again.
- R7: A rising control input while the select is 10 returns it to 01 in the same cycle.
- R8: With the supply below lockout, the select is 01 if the high rail is above 3 V and 11 otherwise, regardless of the enable inputs.
- R9: With supply good and enabled but monitor reset low, the select is 01 if the high rail is above 3 V and 11 otherwise. Any pending delay is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable pin level |
| dly_en_i | input | 1 | Enable-delay threshold crossed |
| vin_ok_i | input | 1 | Input supply above lockout |
| vgh_ok_i | input | 1 | High rail above 3 V |
| mon_rst_i | input | 1 | Supply-monitor reset, high when supply is valid |
| ctl_i | input | 1 | Control input from the timing controller |
| ce_hold_i | input | 1 | Delay pin held above threshold 1 (zero-delay mode) |
| dly_cnt_i | input | CNT_W | Falling-edge delay in clock cycles |
| drv_sel_o | output | 2 | Drive select (R1 encoding) |
| ce_charge_o | output | 1 | Charge command for the delay element |
| ce_clear_o | output | 1 | Clear command for the delay element |

## Verification
Boundary timing on the delay is probed with counts of 1 and 5. A counter that is off by one would switch to the low reference one cycle early or late. A design that failed to reload the count would cut short the delay after a canceled fall. Zero-delay is reached both through the hold pin and through a zero count, and a design that ignored either path would hold 01 and raise charge. The power-loss and monitor-reset paths are driven with the rail flag both high and low, and with the enables low. A design with the wrong priority would ground the node or drive the rail after it has collapsed.

// File: rtl/gate_pulse_seq.sv
module gate_pulse_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             dly_en_i,
  input  logic             vin_ok_i,
  input  logic             vgh_ok_i,
  input  logic             mon_rst_i,
  input  logic             ctl_i,
  input  logic             ce_hold_i,
  input  logic [CNT_W-1:0] dly_cnt_i,
  output logic [1:0]       drv_sel_o,
  output logic             ce_charge_o,
  output logic             ce_clear_o
);
  localparam logic [1:0] SEL_GND = 2'b00;
  localparam logic [1:0] SEL_HI  = 2'b01;
  localparam logic [1:0] SEL_LO  = 2'b10;
  localparam logic [1:0] SEL_OFF = 2'b11;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {PH_HI, PH_WAIT, PH_LO} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] remain;

  wire run       = vin_ok_i & en_i & dly_en_i & mon_rst_i;
  wire zero_mode = ce_hold_i | (dly_cnt_i == '0);
  wire rail_sel  = vgh_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_HI;
      remain <= '0;
    end else if (!run || ctl_i) begin
      phase  <= PH_HI;
      remain <= '0;
    end else begin
      case (phase)
        PH_HI: begin
          if (zero_mode || dly_cnt_i == ONE) phase <= PH_LO;
          else begin
            phase  <= PH_WAIT;
            remain <= dly_cnt_i - ONE;
          end
        end
        PH_WAIT: begin
          if (zero_mode || remain == ONE) phase <= PH_LO;
          else remain <= remain - ONE;
        end
        PH_LO:   phase <= PH_LO;
        default: phase <= PH_HI;
      endcase
    end
  end

  always_comb begin
    if (!vin_ok_i)                 drv_sel_o = rail_sel ? SEL_HI : SEL_OFF;
    else if (!(en_i && dly_en_i))  drv_sel_o = SEL_GND;
    else if (!mon_rst_i)           drv_sel_o = rail_sel ? SEL_HI : SEL_OFF;
    else if (ctl_i)                drv_sel_o = SEL_HI;
    else if (phase == PH_LO || zero_mode) drv_sel_o = SEL_LO;
    else                           drv_sel_o = SEL_HI;
  end

  assign ce_charge_o = run & ~ctl_i & ~zero_mode & (phase != PH_LO);
  assign ce_clear_o  = run & ctl_i & ~ce_hold_i;

endmodule

// File: rtl/gate_pulse_seq_chk.sv
module gate_pulse_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             dly_en_i,
  input logic             vin_ok_i,
  input logic             vgh_ok_i,
  input logic             mon_rst_i,
  input logic             ctl_i,
  input logic             ce_hold_i,
  input logic [CNT_W-1:0] dly_cnt_i,
  input logic [1:0]       drv_sel_o,
  input logic             ce_charge_o,
  input logic             ce_clear_o
);
  wire act = vin_ok_i & en_i & dly_en_i & mon_rst_i;

  p_gnd_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_ok_i && !(en_i && dly_en_i)) |-> drv_sel_o == 2'b00);

  p_high_when_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ctl_i) |-> (drv_sel_o == 2'b01 && !ce_charge_o));

  p_hold_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && !ctl_i && $past(ctl_i) && !ce_hold_i && dly_cnt_i != '0)
      |-> (drv_sel_o == 2'b01 && ce_charge_o));

  p_charge_then_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce_charge_o) && act && !ctl_i) |-> drv_sel_o == 2'b10);

  p_zero_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !ctl_i && ce_hold_i) |-> (drv_sel_o == 2'b10 && !ce_charge_o));

  p_low_needs_ctl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_sel_o == 2'b10 |-> (!ctl_i && act));

  p_float_only_rail_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_sel_o == 2'b11 |-> !vgh_ok_i);

  p_clear_not_charge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_clear_o && ce_charge_o));
endmodule

bind gate_pulse_seq gate_pulse_seq_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/gate_pulse_seq_tb_top.sv
module gate_pulse_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, dly_en_i = 0, vin_ok_i = 0, vgh_ok_i = 0;
  logic mon_rst_i = 0, ctl_i = 0, ce_hold_i = 0;
  logic [CNT_W-1:0] dly_cnt_i = '0;
  logic [1:0] drv_sel_o;
  logic ce_charge_o, ce_clear_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gate_pulse_seq #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string req, input logic [1:0] exp_sel,
                     input logic exp_chg, input logic exp_clr);
    n_chk++;
    if (drv_sel_o !== exp_sel || ce_charge_o !== exp_chg || ce_clear_o !== exp_clr) begin
      n_fail++;
      $display("FAIL %s: sel=%b chg=%b clr=%b expected sel=%b chg=%b clr=%b",
               req, drv_sel_o, ce_charge_o, ce_clear_o, exp_sel, exp_chg, exp_clr);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic normal(input logic [CNT_W-1:0] cnt);
    vin_ok_i = 1; vgh_ok_i = 1; en_i = 1; dly_en_i = 1; mon_rst_i = 1;
    ce_hold_i = 0; ctl_i = 1; dly_cnt_i = cnt;
    step();
  endtask

  task automatic t_reset_off();
    vin_ok_i = 1; vgh_ok_i = 1; en_i = 0; dly_en_i = 1; mon_rst_i = 1; ctl_i = 1;
    #1 chk("R1 enable pin low", 2'b00, 0, 0);
    en_i = 1; dly_en_i = 0; ctl_i = 0;
    step(); chk("R1 enable-delay low", 2'b00, 0, 0);
  endtask

  task automatic t_high();
    normal(16'd3);
    chk("R2 ctl high", 2'b01, 0, 1);
    ce_hold_i = 1; #1 chk("R2 no clear with hold", 2'b01, 0, 0);
    ce_hold_i = 0;
  endtask

  task automatic t_delay(input logic [CNT_W-1:0] n);
    normal(n);
    ctl_i = 0;
    #1 chk("R3 just after fall", 2'b01, 1, 0);
    for (int k = 1; k < int'(n); k++) begin
      step(); chk("R3 still waiting", 2'b01, 1, 0);
    end
    step(); chk("R3 low at N-th edge", 2'b10, 0, 0);
    step(); chk("R3 stays low", 2'b10, 0, 0);
    ctl_i = 1; #1 chk("R7 rise from low", 2'b01, 0, 1);
    step();
  endtask

  task automatic t_zero();
    normal(16'd7);
    ce_hold_i = 1; ctl_i = 0;
    #1 chk("R4 hold zero-delay", 2'b10, 0, 0);
    step(); chk("R4 stays low", 2'b10, 0, 0);
    normal(16'd0);
    ctl_i = 0;
    #1 chk("R5 zero count", 2'b10, 0, 0);
    step(); chk("R5 stays low", 2'b10, 0, 0);
  endtask

  task automatic t_cancel();
    normal(16'd4);
    ctl_i = 0; step(); step();
    chk("R6 waiting", 2'b01, 1, 0);
    ctl_i = 1; #1 chk("R6 cancel", 2'b01, 0, 1);
    step();
    ctl_i = 0;
    for (int k = 1; k < 4; k++) begin
      step(); chk("R6 full delay again", 2'b01, 1, 0);
    end
    step(); chk("R6 low after full count", 2'b10, 0, 0);
  endtask

  task automatic t_power();
    normal(16'd2);
    en_i = 0; vin_ok_i = 0;
    #1 chk("R8 uvlo rail ok", 2'b01, 0, 0);
    vgh_ok_i = 0; #1 chk("R8 uvlo rail low", 2'b11, 0, 0);
    step(); chk("R8 stays undriven", 2'b11, 0, 0);
  endtask

  task automatic t_monrst();
    normal(16'd3);
    ctl_i = 0; step();
    mon_rst_i = 0;
    #1 chk("R9 reset rail ok", 2'b01, 0, 0);
    vgh_ok_i = 0; #1 chk("R9 reset rail low", 2'b11, 0, 0);
    step(); step(); step();
    vgh_ok_i = 1; mon_rst_i = 1;
    #1 chk("R9 delay abandoned", 2'b01, 1, 0);
    step(); step(); chk("R9 full wait restart", 2'b01, 1, 0);
    step(); chk("R9 low after restart", 2'b10, 0, 0);
  endtask

  initial begin
    vin_ok_i = 1; en_i = 0;
    #1 chk("R1 in reset", 2'b00, 0, 0);
    step(); rst_n = 1; step();
    t_reset_off();
    t_high();
    t_delay(16'd1);
    t_delay(16'd5);
    t_zero();
    t_cancel();
    t_power();
    t_monrst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule